// File: doc/BRIEF.md
# Free-running sequential Booth multiplier for unsigned operands

This block multiplies two unsigned operands using radix-2 Booth recoding, one recoding step per clock. It has no start strobe and no completion flag. It repeats one fixed cycle without stopping. On the first edge of each cycle it captures both operands. On each of the following `OP_W + 1` edges it carries out one add/subtract-and-shift step. On the last step it writes the full-width product into an output register, which holds it until the next product is ready. The next edge begins a new capture.

Booth recoding reads its multiplier as two's complement. An unsigned operand with its top bit set would therefore be taken as negative. To prevent this, both operands are zero-extended by one bit, and the recoding runs one step more than the operand width. The accumulator carries one further guard bit, so subtracting the multiplicand can never wrap.

An operand pair is seen correctly if it is held stable across the capture edge. The user can then read the product `OP_W + 2` cycles after that capture edge.

Top module: `booth_free_mult`

## Requirements
- R1: While `rst` is high, `result` is 0 on the following edge. After `rst` is released, `result` stays 0 until the first product is published on the 6th rising edge.
- R2: Every published `result` equals the unsigned product `a*b` of the captured operands, with all 8 bits kept. This holds for all 256 operand pairs, including operands with bit 3 set.
- R3: Operands are captured only on the capture edge, which is the first edge after reset or the edge after a publish. Changes on `a` or `b` during the five step edges that follow have no effect on the product being formed.
- R4: `result` changes only on the final step edge. On every other edge it keeps its value.
- R5: A new product is published every 6 clock cycles (capture plus 5 steps). The cycle after a publish is always a capture.
- R6: Each step examines the pair {multiplier LSB, appended bit}, where the appended bit starts at 0. Pair 01 adds the multiplicand to the upper accumulator, pair 10 subtracts it, and pairs 00 and 11 leave it unchanged. An arithmetic right shift of the combined register follows. At most one of add or subtract is active, and neither is active during a capture.
- R7: The accumulator never overflows. At publish, every bit of the combined register above the 8-bit product is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a | input | OP_W (4) | Unsigned multiplicand |
| b | input | OP_W (4) | Unsigned multiplier |
| result | output | 2*OP_W (8) | Last completed product, held between publishes |

## Verification
The bench builds the block with its default `OP_W = 4`. At that width all 256 operand pairs fit in a short run, so the sweep covers every Booth pair sequence the recoding can meet. This includes the operands with the top bit set, which are the ones the extra zero-extension step exists to serve. The small width also keeps the 6-cycle period short. Per-cycle checks of when `result` may change, mid-computation operand changes and a reset in mid-run therefore all fit beside the exhaustive sweep.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Controller phase: capture operands, or run recoding steps.
  typedef enum logic {
    PH_CAPTURE = 1'b0,
    PH_STEP    = 1'b1
  } phase_t;

  // Action chosen by one Booth recoding step.
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_t;

  // Recode the pair {multiplier lsb, appended bit} into an action.
  function automatic booth_act_t booth_decode(input logic lsb, input logic appended);
    case ({lsb, appended})
      2'b01:   booth_decode = ACT_ADD;
      2'b10:   booth_decode = ACT_SUB;
      default: booth_decode = ACT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int STEPS = 5
) (
  input  logic clk,
  input  logic rst,
  output logic load_evt,
  output logic step_evt,
  output logic last_evt
);
  import booth_pkg::*;

  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS - 1);

  phase_t        phase_q;
  logic [CW-1:0] idx_q;

  assign load_evt = (phase_q == PH_CAPTURE);
  assign step_evt = (phase_q == PH_STEP);
  assign last_evt = step_evt && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CAPTURE;
      idx_q   <= '0;
    end else if (load_evt) begin
      phase_q <= PH_STEP;
      idx_q   <= '0;
    end else if (last_evt) begin
      phase_q <= PH_CAPTURE;
      idx_q   <= '0;
    end else begin
      idx_q   <= idx_q + CW'(1);
    end
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int OP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_evt,
  input  logic                     step_evt,
  input  logic [OP_W-1:0]          a,
  input  logic [OP_W-1:0]          b,
  output logic [OP_W-1:0]          opa_q,
  output logic [OP_W-1:0]          opb_q,
  output logic                     op_add,
  output logic                     op_sub,
  output logic [2*OP_W-1:0]        prod_next,
  output logic [OP_W+2+OP_W:2*OP_W] prod_hi
);
  import booth_pkg::*;

  localparam int EW = OP_W + 1;      // zero-extended operand width
  localparam int AW = EW + 1;        // accumulator with guard bit
  localparam int CW = AW + EW + 1;   // accumulator, multiplier, appended bit
  localparam int FW = AW + EW;       // full product register width

  logic [AW-1:0] acc_q, mcand_q;
  logic [EW-1:0] mq_q;
  logic          app_q;

  booth_act_t    act;
  logic [AW-1:0] acc_sum;
  logic [CW-1:0] joined, shifted;
  logic [FW-1:0] full_next;

  // One add/subtract step followed by an arithmetic right shift.
  function automatic logic [CW-1:0] booth_shift(input logic [AW-1:0] acc,
                                                input logic [EW-1:0] mq,
                                                input logic          app);
    logic [CW-1:0] cat;
    cat = {acc, mq, app};
    booth_shift = {acc[AW-1], cat[CW-1:1]};
  endfunction

  assign act     = step_evt ? booth_decode(mq_q[0], app_q) : ACT_NONE;
  assign op_add  = (act == ACT_ADD);
  assign op_sub  = (act == ACT_SUB);

  always_comb begin
    case (act)
      ACT_ADD: acc_sum = acc_q + mcand_q;
      ACT_SUB: acc_sum = acc_q - mcand_q;
      default: acc_sum = acc_q;
    endcase
  end

  assign joined    = {acc_sum, mq_q, app_q};
  assign shifted   = booth_shift(acc_sum, mq_q, app_q);
  assign full_next = shifted[CW-1:1];
  assign prod_next = full_next[2*OP_W-1:0];
  assign prod_hi   = full_next[FW-1:2*OP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mq_q    <= '0;
      app_q   <= 1'b0;
      opa_q   <= '0;
      opb_q   <= '0;
    end else if (load_evt) begin
      acc_q   <= '0;
      mcand_q <= AW'(a);
      mq_q    <= EW'(b);
      app_q   <= 1'b0;
      opa_q   <= a;
      opb_q   <= b;
    end else if (step_evt) begin
      acc_q   <= shifted[CW-1:EW+1];
      mq_q    <= shifted[EW:1];
      app_q   <= shifted[0];
    end
  end

  // joined is kept for readability of the shift; its lsb part mirrors state.
  logic unused_join;
  assign unused_join = ^joined;

endmodule

// File: rtl/booth_result_reg.sv
module booth_result_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pub_evt,
  input  logic [PW-1:0] prod_next,
  output logic [PW-1:0] result
);

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (pub_evt) result <= prod_next;
  end

endmodule

// File: rtl/booth_free_mult.sv
module booth_free_mult #(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  output logic [2*OP_W-1:0] result
);

  localparam int STEPS = OP_W + 1;
  localparam int PW    = 2 * OP_W;

  // Named internal events, brought out for the bound checker.
  logic                     load_evt;
  logic                     step_evt;
  logic                     pub_evt;
  logic                     op_add;
  logic                     op_sub;
  logic [OP_W-1:0]          opa_q;
  logic [OP_W-1:0]          opb_q;
  logic [PW-1:0]            prod_next;
  logic [OP_W+2+OP_W:PW]    prod_hi;

  booth_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .last_evt (pub_evt)
  );

  booth_datapath #(.OP_W(OP_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load_evt  (load_evt),
    .step_evt  (step_evt),
    .a         (a),
    .b         (b),
    .opa_q     (opa_q),
    .opb_q     (opb_q),
    .op_add    (op_add),
    .op_sub    (op_sub),
    .prod_next (prod_next),
    .prod_hi   (prod_hi)
  );

  booth_result_reg #(.PW(PW)) u_res (
    .clk       (clk),
    .rst       (rst),
    .pub_evt   (pub_evt),
    .prod_next (prod_next),
    .result    (result)
  );

endmodule

// File: rtl/booth_free_mult_chk.sv
module booth_free_mult_chk #(
  parameter int OP_W = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*OP_W-1:0]     result,
  input logic                  load_evt,
  input logic                  step_evt,
  input logic                  pub_evt,
  input logic                  op_add,
  input logic                  op_sub,
  input logic [OP_W-1:0]       opa_q,
  input logic [OP_W-1:0]       opb_q,
  input logic [OP_W+2+OP_W:2*OP_W] prod_hi
);
  localparam int PW = 2 * OP_W;

  // R1: reset clears the product register
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (result == '0));

  // R2: published value is the true unsigned product of captured operands
  a_r2_product: assert property (@(posedge clk) disable iff (rst)
    pub_evt |=> (result == $past(PW'(opa_q) * PW'(opb_q))));

  // R3: captured operands move only on a capture edge
  a_r3_operands_frozen: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> ($stable(opa_q) && $stable(opb_q)));

  // R4: result moves only on the final step
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !pub_evt |=> $stable(result));

  // R5: capture follows publish, steps follow capture
  a_r5_capture_after_pub: assert property (@(posedge clk) disable iff (rst)
    pub_evt |=> load_evt);
  a_r5_step_after_capture: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> step_evt);

  // R6: at most one arithmetic action, none while capturing
  a_r6_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_add, op_sub}));
  a_r6_idle_on_capture: assert property (@(posedge clk) disable iff (rst)
    load_evt |-> !(op_add || op_sub));

  // R7: no overflow into bits above the product
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    pub_evt |-> (prod_hi == '0));

endmodule

bind booth_free_mult booth_free_mult_chk #(.OP_W(OP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .result   (result),
  .load_evt (load_evt),
  .step_evt (step_evt),
  .pub_evt  (pub_evt),
  .op_add   (op_add),
  .op_sub   (op_sub),
  .opa_q    (opa_q),
  .opb_q    (opb_q),
  .prod_hi  (prod_hi)
);

// File: tb/booth_free_mult_test.sv
module booth_free_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W = 4;
  localparam int PER  = OP_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [OP_W-1:0]  a = '0;
  logic [OP_W-1:0]  b = '0;
  logic [2*OP_W-1:0] result;

  int n_run  = 0;
  int n_fail = 0;

  booth_free_mult #(.OP_W(OP_W)) uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: result=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full period: inputs set now (at negedge), next posedge is capture.
  task automatic run_one(input int x, input int y, input string req);
    a = OP_W'(x); b = OP_W'(y);
    repeat (PER) @(posedge clk);
    @(negedge clk);
    check(req, int'(result), x * y);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset clears", int'(result), 0);
    rst = 1'b0;
    a = 4'd7; b = 4'd9;
    for (int k = 1; k < PER; k++) begin
      @(posedge clk); @(negedge clk);
      check("R1 zero before first product", int'(result), 0);
    end
    @(posedge clk); @(negedge clk);
    check("R1 R5 first product on 6th edge", int'(result), 63);
  endtask

  task automatic t_sweep;
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run_one(x, y, "R2 R6 exhaustive");
  endtask

  task automatic t_corners;
    run_one(15, 15, "R7 R6 max operands");
    run_one(8, 8, "R2 top bits set");
    run_one(15, 0, "R6 zero multiplier");
    run_one(0, 15, "R6 zero multiplicand");
    run_one(10, 5, "R6 alternating pairs");
  endtask

  task automatic t_hold_timing;
    int prev;
    run_one(3, 4, "R5 setup");
    prev = int'(result);
    a = 4'd11; b = 4'd13;
    for (int k = 1; k < PER; k++) begin
      @(posedge clk); @(negedge clk);
      check("R4 held during steps", int'(result), prev);
    end
    @(posedge clk); @(negedge clk);
    check("R5 publish on period edge", int'(result), 143);
  endtask

  task automatic t_midchange;
    a = 4'd13; b = 4'd11;
    @(posedge clk); @(negedge clk);
    a = 4'd2; b = 4'd3;
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    check("R3 inputs ignored mid-run", int'(result), 143);
    run_one(2, 3, "R3 next capture sees new inputs");
  endtask

  task automatic t_reset_midrun;
    a = 4'd9; b = 4'd12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 reset mid-run", int'(result), 0);
    rst = 1'b0;
    a = 4'd9; b = 4'd7;
    repeat (PER - 1) @(posedge clk);
    @(negedge clk);
    check("R1 zero until product after reset", int'(result), 0);
    @(posedge clk); @(negedge clk);
    check("R1 R2 product after reset", int'(result), 63);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_hold_timing();
    t_midchange();
    t_reset_midrun();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung, result=%0d expected=done", result);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule